// File: doc/BRIEF.md
# Debug Command Byte Receiver

This block sits behind the debug data register of a test access port and takes in the bytes a host shifts in while the CPU is halted in debug mode. The first byte of each transaction is an operation code. That code sets how many parameter bytes follow and the order in which they are delivered. The block then waits for those bytes with no time limit. A 2-bit status field tells the host whether the block can take a new operation (idle) or whether a service routine is still running (busy).

Two operations are carried out by the block itself: a single-step pulse and a resume pulse. All other operations are passed to a service routine in ROM. For these, the block publishes a 4-bit operation code, enables the ROM, and requests a jump to a fixed service vector. The routine signals completion with a done input. A malformed byte stream can only be cleared by reset, which is the reload of the debug instruction in the port.

Top module: `dbg_cmd_rx`

## Requirements
- R1: After reset, status_o is 2'b01, cmd_code_o and arg_idx_o are 0, and rom_en_o, jump_req_o, step_o, resume_o and arg_valid_o are all 0. status_o only ever takes the values 2'b01 and 2'b10.
- R2: A byte of value 8'h00 received while idle is the return operation. resume_o is high for exactly the one cycle after the byte's clock edge, no jump is made, and status stays 2'b01.
- R3: A byte of value 8'h01 received while idle is the single-step operation. step_o is high for exactly the one cycle after the byte's clock edge, and status stays 2'b01.
- R4: An idle byte whose value is above 8'h08 is discarded. It raises no pulse, no argument and no jump, status stays 2'b01, and the next byte is decoded as a new operation.
- R5: The operations 8'h02 (register map) and 8'h03 (stack) take no parameters. In the cycle after the byte, jump_req_o pulses, cmd_code_o holds the code, and status_o becomes 2'b10.
- R6: Operations 4 (register read), 5 (register write), 6 (memory read), 7 (memory write) and 8 (unlock) take 1, 3, 2, 3 and 4 parameter bytes, respectively. Until the last parameter byte arrives there is no jump and status stays 2'b01. The launch happens in the cycle after the last byte.
- R7: Each parameter byte appears on arg_data_o with arg_valid_o high for one cycle. arg_idx_o counts 0, 1, 2, … in arrival order. A parameter byte whose value matches an operation code is still treated as data.
- R8: There is no timeout. Any number of idle cycles between bytes leaves the partial operation pending and does not change its result.
- R9: While status is 2'b10, incoming bytes produce no pulse, no argument, and no change to status or cmd_code_o. rom_done_i returns status to 2'b01 in the next cycle.
- R10: rom_en_o rises with the first launch and stays high until reset. Whenever jump_req_o pulses, rom_en_o is high. jump_addr_o is 16'h8010.
- R11: A reset during parameter collection abandons the partial operation. The next byte is decoded as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (debug instruction reload) |
| byte_valid_i | input | 1 | One-cycle strobe: a complete byte has been shifted in |
| byte_i | input | 8 | Received byte |
| rom_done_i | input | 1 | Service routine has finished |
| status_o | output | 2 | 2'b01 idle, 2'b10 busy |
| cmd_code_o | output | 4 | Operation code handed to the ROM routine |
| rom_en_o | output | 1 | ROM enable, sticky |
| jump_req_o | output | 1 | One-cycle request to jump to the service vector |
| jump_addr_o | output | 16 | Service vector address |
| step_o | output | 1 | One-cycle single-step pulse |
| resume_o | output | 1 | One-cycle return-to-background pulse |
| arg_valid_o | output | 1 | Parameter byte strobe |
| arg_idx_o | output | 3 | Position of the parameter byte |
| arg_data_o | output | 8 | Parameter byte value |

## Verification
The properties assume that byte_valid_i is a strobe of at most one cycle per byte. They also assume that rom_done_i is raised only while status reads busy, because a done during idle carries no meaning. The bench drives every byte as a single-cycle strobe set up on the falling edge. It pulses rom_done_i only after it has seen status read 2'b10, except in the busy test, where bytes are fed on purpose while the routine is still running.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_RETURN = 4'd0,
    OP_STEP   = 4'd1,
    OP_REGMAP = 4'd2,
    OP_STACK  = 4'd3,
    OP_REG_RD = 4'd4,
    OP_REG_WR = 4'd5,
    OP_MEM_RD = 4'd6,
    OP_MEM_WR = 4'd7,
    OP_UNLOCK = 4'd8
  } dbg_op_e;

  localparam logic [1:0] STAT_IDLE = 2'b01;
  localparam logic [1:0] STAT_BUSY = 2'b10;

  // a byte names an operation when its upper nibble is clear and the code is in range
  function automatic logic op_known(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1:CODE_W] == '0) && (b[CODE_W-1:0] <= OP_UNLOCK);
  endfunction

  // parameter bytes that follow each operation code
  function automatic logic [CNT_W-1:0] op_arg_count(input logic [CODE_W-1:0] c);
    case (c)
      OP_REG_RD: return 3'd1;
      OP_REG_WR: return 3'd3;
      OP_MEM_RD: return 3'd2;
      OP_MEM_WR: return 3'd3;
      OP_UNLOCK: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

  // everything except step and return goes to the service routine
  function automatic logic op_is_rom(input logic [CODE_W-1:0] c);
    return c >= OP_REGMAP;
  endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              known_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  nargs_o,
  output logic              rom_o
);
  always_comb begin
    known_o = op_known(byte_i);
    code_o  = byte_i[CODE_W-1:0];
    nargs_o = op_arg_count(byte_i[CODE_W-1:0]);
    rom_o   = op_is_rom(byte_i[CODE_W-1:0]);
  end
endmodule

// File: rtl/dbg_arg_counter.sv
module dbg_arg_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  logic [CNT_W-1:0] target_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      idx_o    <= '0;
    end else if (load_i) begin
      target_q <= target_i;
      idx_o    <= '0;
    end else if (adv_i) begin
      idx_o    <= idx_o + 1'b1;
    end
  end

  assign last_o = (idx_o == target_q - 1'b1);
endmodule

// File: rtl/dbg_cmd_rx.sv
module dbg_cmd_rx
  import dbg_cmd_pkg::*;
#(
  parameter int              VEC_W       = 16,
  parameter logic [VEC_W-1:0] SERVICE_VEC = 16'h8010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              rom_done_i,
  output logic [1:0]        status_o,
  output logic [3:0]        cmd_code_o,
  output logic              rom_en_o,
  output logic              jump_req_o,
  output logic [VEC_W-1:0]  jump_addr_o,
  output logic              step_o,
  output logic              resume_o,
  output logic              arg_valid_o,
  output logic [2:0]        arg_idx_o,
  output logic [7:0]        arg_data_o
);
  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_BUSY} rx_state_e;
  rx_state_e state_q;

  logic              dec_known, dec_rom;
  logic [CODE_W-1:0] dec_code, pend_code_q;
  logic [CNT_W-1:0]  dec_nargs, cnt_idx;
  logic              cnt_last;

  // named events
  logic byte_take, cmd_ev, arg_ev, collect_ev, launch_ev, step_ev, resume_ev, done_ev;

  dbg_cmd_decode u_dec (
    .byte_i  (byte_i),
    .known_o (dec_known),
    .code_o  (dec_code),
    .nargs_o (dec_nargs),
    .rom_o   (dec_rom)
  );

  dbg_arg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (collect_ev),
    .target_i (dec_nargs),
    .adv_i    (arg_ev),
    .idx_o    (cnt_idx),
    .last_o   (cnt_last)
  );

  always_comb begin
    byte_take  = byte_valid_i && (state_q != S_BUSY);
    cmd_ev     = byte_take && (state_q == S_IDLE) && dec_known;
    arg_ev     = byte_take && (state_q == S_COLLECT);
    collect_ev = cmd_ev && (dec_nargs != '0);
    launch_ev  = (cmd_ev && dec_rom && (dec_nargs == '0)) || (arg_ev && cnt_last);
    step_ev    = cmd_ev && (dec_code == OP_STEP);
    resume_ev  = cmd_ev && (dec_code == OP_RETURN);
    done_ev    = (state_q == S_BUSY) && rom_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pend_code_q <= '0;
      cmd_code_o  <= '0;
      rom_en_o    <= 1'b0;
      jump_req_o  <= 1'b0;
      step_o      <= 1'b0;
      resume_o    <= 1'b0;
      arg_valid_o <= 1'b0;
      arg_idx_o   <= '0;
      arg_data_o  <= '0;
    end else begin
      jump_req_o  <= launch_ev;
      step_o      <= step_ev;
      resume_o    <= resume_ev;
      arg_valid_o <= arg_ev;
      if (arg_ev) begin
        arg_idx_o  <= cnt_idx;
        arg_data_o <= byte_i;
      end
      if (collect_ev) pend_code_q <= dec_code;
      if (launch_ev) begin
        cmd_code_o <= (state_q == S_IDLE) ? dec_code : pend_code_q;
        rom_en_o   <= 1'b1;
        state_q    <= S_BUSY;
      end else if (collect_ev) begin
        state_q    <= S_COLLECT;
      end else if (done_ev) begin
        state_q    <= S_IDLE;
      end
    end
  end

  assign status_o    = (state_q == S_BUSY) ? STAT_BUSY : STAT_IDLE;
  assign jump_addr_o = SERVICE_VEC;
endmodule

// File: rtl/dbg_cmd_rx_chk.sv
module dbg_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid_i,
  input logic       rom_done_i,
  input logic [1:0] status_o,
  input logic [3:0] cmd_code_o,
  input logic       rom_en_o,
  input logic       jump_req_o,
  input logic       step_o,
  input logic       resume_o,
  input logic       arg_valid_o
);
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b01) || (status_o == 2'b10));
  p_resume_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);
  p_resume_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (status_o == 2'b01) && !jump_req_o);
  p_step_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);
  p_jump_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req_o |-> (status_o == 2'b10));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == 2'b10) && !rom_done_i) |=> (status_o == 2'b10) && !arg_valid_o && !step_o && !resume_o);
  p_busy_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == 2'b10) && !rom_done_i) |=> $stable(cmd_code_o));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == 2'b10) && rom_done_i) |=> (status_o == 2'b01));
  p_rom_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |=> rom_en_o);
  p_jump_rom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req_o |-> rom_en_o);
endmodule

bind dbg_cmd_rx dbg_cmd_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_valid_i (byte_valid_i),
  .rom_done_i   (rom_done_i),
  .status_o     (status_o),
  .cmd_code_o   (cmd_code_o),
  .rom_en_o     (rom_en_o),
  .jump_req_o   (jump_req_o),
  .step_o       (step_o),
  .resume_o     (resume_o),
  .arg_valid_o  (arg_valid_o)
);

// File: tb/tb_dbg_cmd_rx.sv
module tb_dbg_cmd_rx;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic rom_done_i = 1'b0;
  logic [1:0] status_o;
  logic [3:0] cmd_code_o;
  logic rom_en_o, jump_req_o, step_o, resume_o, arg_valid_o;
  logic [15:0] jump_addr_o;
  logic [2:0] arg_idx_o;
  logic [7:0] arg_data_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .rom_done_i(rom_done_i), .status_o(status_o), .cmd_code_o(cmd_code_o),
    .rom_en_o(rom_en_o), .jump_req_o(jump_req_o), .jump_addr_o(jump_addr_o),
    .step_o(step_o), .resume_o(resume_o), .arg_valid_o(arg_valid_o),
    .arg_idx_o(arg_idx_o), .arg_data_o(arg_data_o)
  );

  // parameter byte counts restated from the requirements
  function automatic int exp_len(input int code);
    if (code == 4) return 1;
    if (code == 5 || code == 7) return 3;
    if (code == 6) return 2;
    if (code == 8) return 4;
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one byte; on return the outputs show the effect of its clock edge
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
  endtask

  task automatic rom_finish(input string req);
    @(negedge clk);
    rom_done_i = 1'b1;
    @(negedge clk);
    rom_done_i = 1'b0;
    chk(req, "status after done", status_o, 2'b01);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "status", status_o, 2'b01);
    chk("R1", "cmd_code", cmd_code_o, 0);
    chk("R1", "pulses", {rom_en_o, jump_req_o, step_o, resume_o, arg_valid_o}, 0);
    chk("R1", "arg_idx", arg_idx_o, 0);
  endtask

  task automatic t_return();
    send(8'h00);
    chk("R2", "resume", resume_o, 1);
    chk("R2", "jump", jump_req_o, 0);
    chk("R2", "status", status_o, 2'b01);
    @(negedge clk);
    chk("R2", "resume width", resume_o, 0);
  endtask

  task automatic t_step();
    send(8'h01);
    chk("R3", "step", step_o, 1);
    chk("R3", "status", status_o, 2'b01);
    @(negedge clk);
    chk("R3", "step width", step_o, 0);
  endtask

  task automatic t_unknown();
    send(8'h09);
    chk("R4", "outputs after 09", {jump_req_o, step_o, resume_o, arg_valid_o}, 0);
    send(8'h41);
    chk("R4", "outputs after 41", {jump_req_o, step_o, resume_o, arg_valid_o}, 0);
    chk("R4", "status", status_o, 2'b01);
    send(8'h01);
    chk("R4", "next byte is a command", step_o, 1);
  endtask

  task automatic t_rom_zero(input int code);
    send(8'(code));
    chk("R5", "jump", jump_req_o, 1);
    chk("R5", "cmd_code", cmd_code_o, code);
    chk("R5", "status", status_o, 2'b10);
    chk("R10", "rom_en", rom_en_o, 1);
    chk("R10", "jump_addr", jump_addr_o, 16'h8010);
    rom_finish("R9");
    chk("R10", "rom_en sticky", rom_en_o, 1);
  endtask

  task automatic t_multi(input int code, input int gap);
    int n;
    n = exp_len(code);
    send(8'(code));
    chk("R6", "no jump after op byte", jump_req_o, 0);
    chk("R6", "status collecting", status_o, 2'b01);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = (i == 0) ? 8'h01 : 8'(8'hA0 + i);
      repeat (gap) @(negedge clk);
      if (gap > 0) chk("R8", "status during gap", status_o, 2'b01);
      send(d);
      chk("R7", "arg_valid", arg_valid_o, 1);
      chk("R7", "arg_idx", arg_idx_o, i);
      chk("R7", "arg_data", arg_data_o, d);
      chk("R7", "data byte not a step", step_o, 0);
      if (i < n - 1) begin
        chk("R6", "early jump", jump_req_o, 0);
        chk("R6", "early busy", status_o, 2'b01);
      end else begin
        chk("R6", "jump on last", jump_req_o, 1);
        chk("R6", "busy on last", status_o, 2'b10);
        chk("R6", "cmd_code", cmd_code_o, code);
      end
    end
    rom_finish("R9");
  endtask

  task automatic t_busy_ignore();
    send(8'h03);
    chk("R9", "busy", status_o, 2'b10);
    send(8'h01);
    chk("R9", "step ignored", step_o, 0);
    send(8'h00);
    chk("R9", "resume ignored", resume_o, 0);
    send(8'h07);
    chk("R9", "arg ignored", arg_valid_o, 0);
    chk("R9", "cmd_code held", cmd_code_o, 3);
    chk("R9", "still busy", status_o, 2'b10);
    rom_finish("R9");
    send(8'h01);
    chk("R9", "step accepted after done", step_o, 1);
  endtask

  task automatic t_reset_mid();
    send(8'h08);
    send(8'h11);
    send(8'h22);
    do_reset();
    chk("R11", "status after reset", status_o, 2'b01);
    chk("R11", "rom_en cleared", rom_en_o, 0);
    send(8'h01);
    chk("R11", "byte decoded as op", step_o, 1);
    chk("R11", "not an arg", arg_valid_o, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_return();
    t_step();
    t_unknown();
    t_rom_zero(2);
    t_rom_zero(3);
    for (int c = 4; c <= 8; c++) t_multi(c, 0);
    t_multi(7, 40);
    t_busy_ignore();
    t_reset_mid();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule